// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block conditions a single external interrupt request pin for a small microcontroller. The raw pin is brought into the clock domain through a synchronizer chain. The block then watches for the programmed transition, or for the transition together with the asserted level. Events latch into a status flag. Software can poll the flag, clear it with a write-one acknowledge bit, or let it drive an interrupt request line when interrupts are enabled.

One 8-bit control and status register holds the whole configuration. It covers pin function enable, active direction, detection mode, interrupt enable and the pad pull-device control. The register is written through a single-cycle write strobe and read back combinationally from registered state. Turning the pin function on always sets the flag, so software clears it before it unmasks the interrupt. In edge-and-level mode, the flag cannot be cleared while the pin sits at its active level.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, irq is 0 and pull_en is 0.
- R2: Register bits are: bit 0 mode (0 edge only, 1 edge and level), bit 1 interrupt enable, bit 2 acknowledge (write 1 clears the flag, always reads 0), bit 3 flag (read only), bit 4 pin function enable, bit 5 polarity, bit 6 pull disable, bit 7 reserved (reads 0, writes ignored). Writable bits read back what was written on the cycle after the write.
- R3: While bit 4 is 0, pin activity never sets the flag.
- R4: Polarity 0 detects falling edges and low levels, and polarity 1 detects rising edges and high levels. A pin change that is stable before a rising clock edge shows in the flag after the third rising edge, and not after the second.
- R5: In edge-only mode an acknowledge write clears the flag even while the pin holds its active level. The flag then stays clear until a new active edge arrives.
- R6: In edge-and-level mode the flag is set by the active transition and stays set. Acknowledge writes have no effect while the synchronized pin is at the active level. Once the pin is inactive, an acknowledge clears the flag.
- R7: A write that changes bit 4 from 0 to 1 sets the flag on that clock edge.
- R8: irq is 1 exactly when the flag, interrupt enable and pin enable are all 1. With interrupt enable at 0, irq stays 0 whatever the flag does.
- R9: pull_en is 1 exactly when pin enable is 1 and pull disable is 0.
- R10: When a set event and an acknowledge happen on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_data | input | 8 | Data written to the control and status register |
| rd_data | output | 8 | Current register contents |
| pin_in | input | 1 | Raw external request pin, asynchronous |
| pull_en | output | 1 | Enable for the pad pull device |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that wr_data carries a meaningful value whenever wr_en is high. They also assume that the only path into the flag is the event logic and the write port, so an acknowledge without a concurrent set event must clear the flag in edge mode. The stimulus changes the pin and the write strobe only on falling clock edges. Random pin levels are held for varying spans, so that both single-cycle glitches and long held levels occur. Random writes cover every encoding of the register, including enable toggles that collide with acknowledges and with pin edges.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int REG_W = 8;

  localparam int B_MODE    = 0;
  localparam int B_IE      = 1;
  localparam int B_ACK     = 2;
  localparam int B_FLAG    = 3;
  localparam int B_PEN     = 4;
  localparam int B_POL     = 5;
  localparam int B_PULLOFF = 6;
  localparam int B_RSV     = 7;

  typedef struct packed {
    logic pull_off;
    logic pol;
    logic pin_en;
    logic ie;
    logic mode;
  } ctrl_t;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b0;
        else     stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/extint_detect.sv
module extint_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_sync,
  input  logic pol,
  input  logic mode,
  input  logic pin_en,
  output logic lvl_active,
  output logic set_evt
);

  logic prev_q;
  logic prev_active;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin_sync;
  end

  // polarity 1: high is active; polarity 0: low is active
  assign lvl_active  = pol ? pin_sync : ~pin_sync;
  assign prev_active = pol ? prev_q   : ~prev_q;
  assign edge_hit    = lvl_active & ~prev_active;
  assign set_evt     = pin_en & (edge_hit | (mode & lvl_active));

  // R4: an edge is a single-cycle event unless polarity changes
  p_edge_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && $stable(pol)) |=> (!edge_hit || !$stable(pol)));

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             det_set,
  input  logic             lvl_active,
  output ctrl_t            ctrl_q,
  output logic             flag_q
);

  logic en_rise;
  logic ack;
  logic set_any;
  logic unused_bits;

  assign unused_bits = ^{wr_data[B_RSV], wr_data[B_FLAG]};

  assign en_rise = wr_en & wr_data[B_PEN] & ~ctrl_q.pin_en;
  assign ack     = wr_en & wr_data[B_ACK];
  assign set_any = en_rise | det_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.pull_off <= wr_data[B_PULLOFF];
      ctrl_q.pol      <= wr_data[B_POL];
      ctrl_q.pin_en   <= wr_data[B_PEN];
      ctrl_q.ie       <= wr_data[B_IE];
      ctrl_q.mode     <= wr_data[B_MODE];
    end
  end

  // set outranks acknowledge
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_any) flag_q <= 1'b1;
    else if (ack)     flag_q <= 1'b0;
  end

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !det_set && !en_rise) |=> !flag_q);

  p_level_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.pin_en && ctrl_q.mode && lvl_active) |=> flag_q);

  p_enable_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_PEN] && !ctrl_q.pin_en) |=> flag_q);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && det_set) |=> flag_q);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             pin_in,
  output logic             pull_en,
  output logic             irq
);

  ctrl_t ctrl_q;
  logic  flag_q;
  logic  pin_sync;
  logic  lvl_active;
  logic  det_set;

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  extint_detect u_detect (
    .clk        (clk),
    .rst        (rst),
    .pin_sync   (pin_sync),
    .pol        (ctrl_q.pol),
    .mode       (ctrl_q.mode),
    .pin_en     (ctrl_q.pin_en),
    .lvl_active (lvl_active),
    .set_evt    (det_set)
  );

  extint_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .det_set    (det_set),
    .lvl_active (lvl_active),
    .ctrl_q     (ctrl_q),
    .flag_q     (flag_q)
  );

  // outputs depend on registers only
  always_comb begin
    rd_data             = '0;
    rd_data[B_MODE]     = ctrl_q.mode;
    rd_data[B_IE]       = ctrl_q.ie;
    rd_data[B_FLAG]     = flag_q;
    rd_data[B_PEN]      = ctrl_q.pin_en;
    rd_data[B_POL]      = ctrl_q.pol;
    rd_data[B_PULLOFF]  = ctrl_q.pull_off;
  end

  assign pull_en = ctrl_q.pin_en & ~ctrl_q.pull_off;
  assign irq     = flag_q & ctrl_q.ie & ctrl_q.pin_en;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq && !pull_en));

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.pin_en && !flag_q && !(wr_en && wr_data[B_PEN])) |=> !flag_q);

  p_polled_only_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[B_IE]) |=> !irq);

endmodule

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pin_in = 1'b0;
  logic       pull_en;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  extint_ctrl u_dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pull_en (pull_en),
    .irq     (irq)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_prev, m_flag;
  logic m_poff, m_pol, m_en, m_ie, m_mode;

  always @(posedge clk) begin
    logic act, pact, setv;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
      m_poff <= 0; m_pol <= 0; m_en <= 0; m_ie <= 0; m_mode <= 0;
    end else begin
      act  = m_pol ? m_s2 : ~m_s2;
      pact = m_pol ? m_prev : ~m_prev;
      setv = (wr_en && wr_data[4] && !m_en) ||
             (m_en && act && !pact) || (m_en && m_mode && act);
      if (setv) m_flag <= 1'b1;
      else if (wr_en && wr_data[2]) m_flag <= 1'b0;
      if (wr_en) begin
        m_poff <= wr_data[6]; m_pol <= wr_data[5]; m_en <= wr_data[4];
        m_ie <= wr_data[1]; m_mode <= wr_data[0];
      end
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
    end
  end

  function automatic logic [7:0] exp_rd();
    return {1'b0, m_poff, m_pol, m_en, m_flag, 1'b0, m_ie, m_mode};
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk(rd_data, exp_rd(), "R2 model rd_data");
      chk({7'd0, irq}, {7'd0, m_flag & m_ie & m_en}, "R8 model irq");
      chk({7'd0, pull_en}, {7'd0, m_en & ~m_poff}, "R9 model pull_en");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst = 1'b0;
    step(1);
    mon_on = 1'b1;
    // R1 reset state
    chk(rd_data, 8'h00, "R1 rd_data");
    chk({7'd0, irq}, 8'h00, "R1 irq");
    chk({7'd0, pull_en}, 8'h00, "R1 pull_en");
    // R3 disabled pin ignored
    pin_in = 1'b1; step(4); pin_in = 1'b0; step(4);
    chk(rd_data, 8'h00, "R3 disabled no flag");
    chk({7'd0, pull_en}, 8'h00, "R9 pull off while disabled");
    pin_in = 1'b1; step(4);
    // R7 enable sets flag, polled only
    wr(8'h10);
    chk(rd_data, 8'h18, "R7 enable sets flag");
    chk({7'd0, pull_en}, 8'h01, "R9 pull on");
    chk({7'd0, irq}, 8'h00, "R8 polled no irq");
    wr(8'h14);
    chk(rd_data, 8'h10, "R5 ack clears");
    // R4 falling edge latency
    pin_in = 1'b0; step(2);
    chk(rd_data, 8'h10, "R4 not after two edges");
    step(1);
    chk(rd_data, 8'h18, "R4 falling edge flag");
    chk({7'd0, irq}, 8'h00, "R8 polled no irq");
    // R5 edge mode clear while held
    wr(8'h14);
    chk(rd_data, 8'h10, "R5 ack while low");
    step(5);
    chk(rd_data, 8'h10, "R5 stays clear");
    // R4 rising polarity, R8 irq
    wr(8'h34);
    chk(rd_data, 8'h30, "R2 polarity readback");
    pin_in = 1'b1; step(3);
    chk(rd_data, 8'h38, "R4 rising edge flag");
    wr(8'h36);
    chk(rd_data, 8'h32, "R5 ack while high");
    chk({7'd0, irq}, 8'h00, "R8 irq low after ack");
    pin_in = 1'b0; step(3); pin_in = 1'b1; step(3);
    chk(rd_data, 8'h3A, "R4 second rising edge");
    chk({7'd0, irq}, 8'h01, "R8 irq raised");
    // R6 level mode, polarity 0
    wr(8'h15);
    chk(rd_data, 8'h11, "R6 level mode cleared");
    pin_in = 1'b0; step(3);
    chk(rd_data, 8'h19, "R6 level set");
    wr(8'h15);
    chk(rd_data, 8'h19, "R6 sticky ack ignored");
    step(3); wr(8'h15);
    chk(rd_data, 8'h19, "R6 sticky second ack");
    pin_in = 1'b1; step(3); wr(8'h15);
    chk(rd_data, 8'h11, "R6 ack after release");
    // R6 level mode, polarity 1 with pin already high
    wr(8'h35);
    chk(rd_data, 8'h31, "R6 polarity switch");
    step(1);
    chk(rd_data, 8'h39, "R6 high level sets");
    wr(8'h35);
    chk(rd_data, 8'h39, "R6 high sticky");
    pin_in = 1'b0; step(3); wr(8'h35);
    chk(rd_data, 8'h31, "R6 high release ack");
    // R10 set wins over ack
    wr(8'h04);
    chk(rd_data, 8'h00, "R3 disable and ack");
    wr(8'h14);
    chk(rd_data, 8'h18, "R10 enable beats ack");
    // R9 pull disable, R2 reserved bit
    wr(8'h54);
    chk(rd_data, 8'h50, "R2 pull disable readback");
    chk({7'd0, pull_en}, 8'h00, "R9 pull disabled");
    wr(8'hD4);
    chk(rd_data, 8'h50, "R2 reserved reads zero");
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 7) == 0) pin_in = ~pin_in;
      if ($urandom_range(0, 15) == 0) begin
        wr_en = 1'b1;
        wr_data = 8'($urandom());
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    step(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule